// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. The entry for a branch is picked by a few low bits of the fetch PC, joined with a short global history register. That register holds the outcomes of the most recent branches, whichever branches they were. So one branch owns several counters, one for each history pattern, and its prediction can follow what the branches just before it did.

The front end presents a fetch PC on the lookup port. One cycle later it gets the predicted direction, together with the history value that was used for the lookup. The back end later returns that history on the update port, along with the resolved PC and the real outcome. The block then trains exactly the counter that was read, and shifts the outcome into the global history. After a misprediction, the restore port rebuilds the history from the captured value plus the correct outcome.

Top module: `corr_dir_pred`

## Requirements
- R1: After reset, `pr_valid` is 0, the global history is all zeros and every counter holds weakly taken (2'b10), so the first lookup of any PC predicts taken and reports `pr_hist` = 0.
- R2: A lookup presented in cycle n gives `pr_valid`=1 in cycle n+1, with `pr_taken` equal to bit 1 (the MSB) of the selected counter; with no lookup, `pr_valid` is 0 the next cycle.
- R3: The table index is {PC[OFF_BITS+PC_IDX_BITS-1:OFF_BITS], history}, with history in the low bits; with the defaults this is {pc[7:2], hist[1:0]}. PC bits outside that slice, including the offset bits, do not change the entry, so such PCs alias with no tag check.
- R4: The counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A taken outcome adds one and saturates at 11; a not-taken outcome subtracts one and saturates at 00.
- R5: A counter at strong taken needs two consecutive not-taken updates before its prediction turns to not-taken, and the same holds in the other direction.
- R6: Every update shifts `up_taken` (taken = 1) into history bit 0. The older bits move up one place and the oldest is dropped. With no update or restore, the history stays unchanged. `pr_hist` shows the history that was used by each lookup.
- R7: An update indexes the table with `up_hist`, not with the current history register.
- R8: A restore loads the history with {rs_hist[HIST_BITS-2:0], rs_taken}. When a restore and an update come in the same cycle, the restore sets the history, and the update still trains its counter.
- R9: A lookup and an update to the same entry in the same cycle return the counter value from before the update. The new value is seen from the next lookup on.
- R10: One PC with different history values reads different counters, so each branch has 2^HIST_BITS independent counter sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Fetch PC for the lookup |
| pr_valid | output | 1 | Prediction valid, one cycle after the lookup |
| pr_taken | output | 1 | Predicted direction, 1 = taken |
| pr_hist | output | HIST_BITS | History used by the lookup, to be returned on update or restore |
| up_valid | input | 1 | Resolved-branch update |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_hist | input | HIST_BITS | History captured when the branch was predicted |
| rs_valid | input | 1 | History repair after a misprediction |
| rs_hist | input | HIST_BITS | History captured at prediction of the mispredicted branch |
| rs_taken | input | 1 | Correct outcome of the mispredicted branch |

## Verification
Three things can land in the same cycle and target the same state: a lookup reading an entry while an update trains it, and an update shifting the history while a restore reloads it. The bench drives these collisions on purpose. It looks up and updates one PC with a matching history in the same cycle, and it raises restore and update together. It then checks that the prediction shows the value from before the update, that the next lookup shows the trained value, and that the history reported by the next lookup is the restored one. A reference model in the bench, driven by a dense random phase over a small set of PCs, adds many more such collisions.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;

   typedef enum logic [1:0] {
      CTR_STRONG_NT = 2'b00,
      CTR_WEAK_NT   = 2'b01,
      CTR_WEAK_T    = 2'b10,
      CTR_STRONG_T  = 2'b11
   } ctr_e;

   localparam ctr_e CTR_RESET = CTR_WEAK_T;

   // saturating step of a 2-bit direction counter
   function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
      ctr_e nxt;
      nxt = cur;
      if (taken && cur != CTR_STRONG_T)
         nxt = ctr_e'(cur + 2'd1);
      else if (!taken && cur != CTR_STRONG_NT)
         nxt = ctr_e'(cur - 2'd1);
      return nxt;
   endfunction

endpackage

// File: rtl/corr_hist_reg.sv
module corr_hist_reg #(
   parameter int HIST_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shift_en,
   input  logic                 shift_bit,
   input  logic                 load_en,
   input  logic [HIST_BITS-1:0] load_base,
   input  logic                 load_bit,
   output logic [HIST_BITS-1:0] hist
);

   logic [HIST_BITS-1:0] shifted;
   logic [HIST_BITS-1:0] loaded;

   generate
      if (HIST_BITS == 1) begin : g_single
         assign shifted = shift_bit;
         assign loaded  = load_bit;
      end else begin : g_multi
         assign shifted = {hist[HIST_BITS-2:0], shift_bit};
         assign loaded  = {load_base[HIST_BITS-2:0], load_bit};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         hist <= '0;
      else if (load_en)
         hist <= loaded;
      else if (shift_en)
         hist <= shifted;
   end

   assert_shift_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !load_en) |=> hist[0] == $past(shift_bit));
   assert_restore_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> hist[0] == $past(load_bit));
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en && !load_en) |=> $stable(hist));

endmodule

// File: rtl/corr_ctr_table.sv
module corr_ctr_table
   import corr_bp_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic             rd_taken,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);

   localparam int DEPTH = 1 << IDX_W;

   ctr_e mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= CTR_RESET;
      end else if (wr_en) begin
         mem[wr_idx] <= ctr_step(mem[wr_idx], wr_taken);
      end
   end

   // registered read: sees the value before a same-cycle write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_taken <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         rd_taken <= rd_en & mem[rd_idx][1];
      end
   end

   assert_sat_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken && mem[wr_idx] == CTR_STRONG_T) |=>
         mem[$past(wr_idx)] == CTR_STRONG_T);
   assert_sat_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_taken && mem[wr_idx] == CTR_STRONG_NT) |=>
         mem[$past(wr_idx)] == CTR_STRONG_NT);
   assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == $past(rd_en));

endmodule

// File: rtl/corr_dir_pred.sv
module corr_dir_pred #(
   parameter int PC_W        = 32,
   parameter int OFF_BITS    = 2,
   parameter int PC_IDX_BITS = 6,
   parameter int HIST_BITS   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lk_valid,
   input  logic [PC_W-1:0]      lk_pc,
   output logic                 pr_valid,
   output logic                 pr_taken,
   output logic [HIST_BITS-1:0] pr_hist,
   input  logic                 up_valid,
   input  logic [PC_W-1:0]      up_pc,
   input  logic                 up_taken,
   input  logic [HIST_BITS-1:0] up_hist,
   input  logic                 rs_valid,
   input  logic [HIST_BITS-1:0] rs_hist,
   input  logic                 rs_taken
);

   localparam int IDX_W = PC_IDX_BITS + HIST_BITS;

   generate
      if (HIST_BITS < 1 || HIST_BITS > 12) begin : g_bad_hist
         $error("HIST_BITS out of range");
      end
      if (PC_IDX_BITS < 1 || OFF_BITS < 0 || OFF_BITS + PC_IDX_BITS > PC_W) begin : g_bad_pc
         $error("PC slice does not fit PC_W");
      end
      if (IDX_W > 12) begin : g_bad_size
         $error("table too large");
      end
   endgenerate

   logic [HIST_BITS-1:0] ghr;
   logic [IDX_W-1:0]     lk_idx;
   logic [IDX_W-1:0]     up_idx;

   assign lk_idx = {lk_pc[OFF_BITS +: PC_IDX_BITS], ghr};
   assign up_idx = {up_pc[OFF_BITS +: PC_IDX_BITS], up_hist};

   corr_hist_reg #(.HIST_BITS(HIST_BITS)) i_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (up_valid),
      .shift_bit (up_taken),
      .load_en   (rs_valid),
      .load_base (rs_hist),
      .load_bit  (rs_taken),
      .hist      (ghr)
   );

   corr_ctr_table #(.IDX_W(IDX_W)) i_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (lk_valid),
      .rd_idx   (lk_idx),
      .rd_valid (pr_valid),
      .rd_taken (pr_taken),
      .wr_en    (up_valid),
      .wr_idx   (up_idx),
      .wr_taken (up_taken)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         pr_hist <= '0;
      else if (lk_valid)
         pr_hist <= ghr;
   end

   assert_pred_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pr_valid == $past(lk_valid));
   assert_hist_report_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pr_valid |-> pr_hist == $past(ghr));

endmodule

// File: tb/test_corr_dir_pred.sv
module test_corr_dir_pred;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        pr_valid;
   logic        pr_taken;
   logic [1:0]  pr_hist;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic        up_taken = 1'b0;
   logic [1:0]  up_hist = '0;
   logic        rs_valid = 1'b0;
   logic [1:0]  rs_hist = '0;
   logic        rs_taken = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   corr_dir_pred i_corr_dir_pred (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_pc(lk_pc),
      .pr_valid(pr_valid), .pr_taken(pr_taken), .pr_hist(pr_hist),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist),
      .rs_valid(rs_valid), .rs_hist(rs_hist), .rs_taken(rs_taken)
   );

   typedef struct {
      logic       valid;
      logic       taken;
      logic [1:0] hist;
      string      tag;
   } exp_t;

   exp_t       sb[$];
   logic [1:0] m_ctr [256];
   logic [1:0] m_ghr;
   int         checks = 0;
   int         errors = 0;

   function automatic int m_idx(input logic [31:0] pc, input logic [1:0] h);
      return int'({pc[7:2], h});
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // driver: drive one cycle, model it, push expectation at the edge
   task automatic cyc(input logic lv, input logic [31:0] lp,
                      input logic uv, input logic [31:0] upc, input logic ut, input logic [1:0] uh,
                      input logic rv, input logic [1:0] rh, input logic rt, input string tag);
      exp_t e;
      int   ui;
      @(negedge clk);
      lk_valid = lv; lk_pc = lp;
      up_valid = uv; up_pc = upc; up_taken = ut; up_hist = uh;
      rs_valid = rv; rs_hist = rh; rs_taken = rt;
      e.valid = lv;
      e.taken = lv ? m_ctr[m_idx(lp, m_ghr)][1] : 1'b0;
      e.hist  = m_ghr;
      e.tag   = tag;
      if (uv) begin
         ui = m_idx(upc, uh);
         if (ut && m_ctr[ui] != 2'b11) m_ctr[ui] = m_ctr[ui] + 2'd1;
         else if (!ut && m_ctr[ui] != 2'b00) m_ctr[ui] = m_ctr[ui] - 2'd1;
      end
      if (rv) m_ghr = {rh[0], rt};
      else if (uv) m_ghr = {m_ghr[0], ut};
      @(posedge clk);
      sb.push_back(e);
   endtask

   task automatic look(input logic [31:0] pc, input string tag);
      cyc(1'b1, pc, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, tag);
   endtask

   task automatic train(input logic [31:0] pc, input logic t, input logic [1:0] h, input string tag);
      cyc(1'b0, '0, 1'b1, pc, t, h, 1'b0, '0, 1'b0, tag);
   endtask

   task automatic set_ghr(input logic [1:0] h, input string tag);
      cyc(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, {1'b0, h[1]}, h[0], tag);
   endtask

   // monitor: pop and compare away from the active edge
   always @(negedge clk) begin
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(e.tag, "pr_valid", int'(pr_valid), int'(e.valid));
         if (e.valid) begin
            check(e.tag, "pr_taken", int'(pr_taken), int'(e.taken));
            check(e.tag, "pr_hist", int'(pr_hist), int'(e.hist));
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) m_ctr[i] = 2'b10;
      m_ghr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "pr_valid after reset", int'(pr_valid), 0);

      // R1: fresh counters predict taken, history zero
      look(32'h0000_0100, "R1");
      look(32'h0000_0ffc, "R1");

      // R4 R5: saturate taken, then two not-taken needed to flip
      train(32'h40, 1'b1, 2'b00, "R4");
      train(32'h40, 1'b1, 2'b00, "R4");
      train(32'h40, 1'b1, 2'b00, "R4");
      set_ghr(2'b00, "R8");
      look(32'h40, "R4");
      train(32'h40, 1'b0, 2'b00, "R5");
      set_ghr(2'b00, "R5");
      look(32'h40, "R5");
      train(32'h40, 1'b0, 2'b00, "R5");
      set_ghr(2'b00, "R5");
      look(32'h40, "R5");
      train(32'h40, 1'b0, 2'b00, "R4");
      train(32'h40, 1'b0, 2'b00, "R4");
      train(32'h40, 1'b0, 2'b00, "R4");
      set_ghr(2'b00, "R4");
      look(32'h40, "R4");
      train(32'h40, 1'b1, 2'b00, "R5");
      set_ghr(2'b00, "R5");
      look(32'h40, "R5");

      // R6: shift pattern visible through pr_hist
      train(32'h80, 1'b1, 2'b00, "R6");
      look(32'h80, "R6");
      train(32'h80, 1'b0, 2'b00, "R6");
      look(32'h80, "R6");
      train(32'h80, 1'b1, 2'b00, "R6");
      look(32'h80, "R6");
      look(32'h80, "R6");

      // R7: update index follows up_hist, not current history
      set_ghr(2'b11, "R7");
      train(32'h20, 1'b0, 2'b01, "R7");
      set_ghr(2'b01, "R7");
      look(32'h20, "R7");
      set_ghr(2'b11, "R7");
      look(32'h20, "R7");

      // R10: same PC, different history, separate counters
      train(32'hC0, 1'b0, 2'b10, "R10");
      train(32'hC0, 1'b0, 2'b10, "R10");
      for (int h = 0; h < 4; h++) begin
         set_ghr(2'(h), "R10");
         look(32'hC0, "R10");
      end

      // R3: aliasing through upper PC bits and offset bits
      train(32'h0000_0010, 1'b0, 2'b00, "R3");
      set_ghr(2'b00, "R3");
      look(32'h0001_0013, "R3");
      set_ghr(2'b00, "R3");
      look(32'h0000_0110, "R3");

      // R8: restore and update in the same cycle
      set_ghr(2'b00, "R8");
      cyc(1'b0, '0, 1'b1, 32'h30, 1'b0, 2'b10, 1'b1, 2'b11, 1'b0, "R8");
      look(32'h30, "R8");
      set_ghr(2'b10, "R8");
      look(32'h30, "R8");

      // R9: same-cycle lookup and update on the same entry
      set_ghr(2'b01, "R9");
      cyc(1'b1, 32'h34, 1'b1, 32'h34, 1'b0, 2'b01, 1'b1, 2'b00, 1'b1, "R9");
      look(32'h34, "R9");
      cyc(1'b1, 32'h34, 1'b1, 32'h34, 1'b0, 2'b01, 1'b1, 2'b00, 1'b1, "R9");
      look(32'h34, "R9");

      // R2: idle cycle gives no prediction, then dense random traffic
      cyc(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, "R2");
      for (int n = 0; n < 600; n++) begin
         logic [31:0] a, b;
         a = {24'($urandom_range(0, 3)), 2'b0, 4'($urandom_range(0, 3)), 2'($urandom)};
         b = {24'($urandom_range(0, 3)), 2'b0, 4'($urandom_range(0, 3)), 2'($urandom)};
         cyc(1'($urandom), a, 1'($urandom), b, 1'($urandom), 2'($urandom),
             ($urandom_range(0, 7) == 0), 2'($urandom), 1'($urandom), "R2");
      end
      cyc(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, "R2");
      @(negedge clk);
      @(negedge clk);
      check("R2", "scoreboard drained", sb.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule